// File: doc/BRIEF.md
# Write-Only Serial Configuration Slave for a Three-Channel Video Filter

This block is the digital control front of a three-channel video filter. It listens on a two-wire serial bus as a write-only I2C slave, oversampled by the system clock. It accepts fixed three-byte write frames: device address, register index, data. Each write changes one of three small configuration registers. The analog side reads the decoded results from ports:
- the filter cutoff code;
- the coupling type of each channel;
- power-down;
- filter bypass;
- the half-cutoff enables for the second and third channels;
- the effective input-multiplexer selection.

A two-bit select input models a three-state strap. It chooses one of three device addresses, so up to three such filters can share a bus. The slave acknowledges by pulling SDA low through an open-drain enable. A frame with the wrong address, a read request or an unknown register index is left unacknowledged and changes nothing. The data byte is always acknowledged. The multiplexer selection is a register flag ORed with a direct pin, so the pin can switch inputs at any moment without bus traffic.

Top module: `vfe_i2c_cfg`

## Requirements
- R1: The address byte is acknowledged only when it equals the selected device address with bit 0 clear: `addr_sel` 00 selects 0x90, 01 selects 0x92, and 1x (open strap) selects 0x94. After a refused address, no later byte of the frame is acknowledged and no register changes.
- R2: An address byte with bit 0 set (read request) is never acknowledged, and the frame writes nothing.
- R3: The index byte is acknowledged only for 0x01, 0x02 or 0x03. Any other index gets no acknowledge, and the frame's data byte writes nothing.
- R4: Once address and index are accepted, the data byte is acknowledged whatever its value. `sda_oe` rises and falls only while SCL is low.
- R5: Writing index 0x01 sets `cut_code` to the full 8-bit data value.
- R6: Writing index 0x02 sets the coupling type of channel 1 from data bits 7:6, channel 2 from bits 5:4 and channel 3 from bits 3:2. Pair 00 gives clamp (code 0), pair 01 gives bias (code 1), and pair 1x gives direct (code 2). `chan_mode[1:0]` is channel 1, `[3:2]` is channel 2 and `[5:4]` is channel 3. Code 3 never appears. Bits 1:0 are ignored.
- R7: Writing index 0x03 sets power-down from data bit 7, the multiplexer flag from bit 6, half-cutoff from bit 5 and bypass from bit 4. Bits 3:0 are ignored.
- R8: `sel_b` is high when `mux_pin` is high or the multiplexer flag is set, and follows a `mux_pin` change one clock later.
- R9: `filt_active` is the inverse of bypass. `half_en[0]` (channel 2) and `half_en[1]` (channel 3) equal half-cutoff AND NOT bypass. Channel 1 has no half-cutoff output.
- R10: Exactly one register is written per frame. A byte after the data byte is not acknowledged and changes nothing.
- R11: A stop before the data byte discards the frame. A repeated start at any point restarts address decoding, and the frame that follows it is handled normally.
- R12: After synchronous reset the outputs are: `cut_code` 0x00; channel 1 clamp; channels 2 and 3 bias; power-down, bypass, half-cutoff and multiplexer flag clear; `sda_oe` low.
- R13: A written value is on the outputs before the SCL rising edge that samples the data acknowledge, well inside 1 µs at 400 kbit/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | Open-drain enable; high pulls SDA low |
| addr_sel | input | 2 | Address strap: 00 low, 01 high, 1x open |
| mux_pin | input | 1 | Direct input-B select pin |
| cut_code | output | 8 | Filter cutoff code |
| chan_mode | output | 6 | Per-channel coupling type, 2 bits per channel |
| power_down | output | 1 | Analog power-down request |
| sel_b | output | 1 | Effective multiplexer select (1 = input B) |
| filt_active | output | 1 | Filter path in use (low in bypass) |
| half_en | output | 2 | Half-cutoff enables for channel 2 (bit 0) and channel 3 (bit 1) |

## Verification
The hardest state to reach from the ports is a frame cut short after an accepted index. The bench drives it in two ways. One frame ends with a stop before any data bit. Another gets a repeated start, and then a complete frame whose write must land. A second hard case is the timing of the acknowledge relative to SCL through the synchronizer delay. The bench plays the bus master bit by bit with quarter-period spacing. It samples the line in the middle of the ninth clock and checks the updated register before the stop.

// File: rtl/vfe_cfg_pkg.sv
`timescale 1ns/1ps
package vfe_cfg_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 2;

  localparam logic [IDX_W-1:0]  IDX_CUT  = 2'd1;
  localparam logic [IDX_W-1:0]  IDX_TYPE = 2'd2;
  localparam logic [IDX_W-1:0]  IDX_CTRL = 2'd3;
  localparam logic [BYTE_W-1:0] IDX_LAST = 8'd3;

  typedef enum logic [1:0] {
    MODE_CLAMP  = 2'd0,
    MODE_BIAS   = 2'd1,
    MODE_DIRECT = 2'd2
  } in_mode_e;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_SHIFT,
    FS_ACK,
    FS_HOLD
  } fsm_e;

  typedef struct packed {
    logic pd;
    logic mux;
    logic half;
    logic byp;
  } ctrl_t;

  function automatic in_mode_e decode_pair(input logic [1:0] p);
    if (p[1])      return MODE_DIRECT;
    else if (p[0]) return MODE_BIAS;
    else           return MODE_CLAMP;
  endfunction

endpackage

// File: rtl/vfe_i2c_sync.sv
`timescale 1ns/1ps
module vfe_i2c_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic              scl_d;
  logic              sda_d;
  logic              scl_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[TOP];
      sda_d  <= sda_sh[TOP];
    end
  end

  assign scl_now   = scl_sh[TOP];
  assign sda_q     = sda_sh[TOP];
  assign scl_rise  = scl_now & ~scl_d;
  assign scl_fall  = ~scl_now & scl_d;
  // SDA edges while SCL stays high frame a transfer
  assign start_det = scl_now & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_now & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/vfe_i2c_wr_fsm.sv
`timescale 1ns/1ps
module vfe_i2c_wr_fsm
  import vfe_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] BITS = CNT_W'(BYTE_W);

  fsm_e              state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [1:0]        byte_no;
  logic              byte_ok;

  always_comb begin
    case (byte_no)
      2'd0:    byte_ok = (shreg == {dev_addr, 1'b0});
      2'd1:    byte_ok = (shreg != '0) && (shreg <= IDX_LAST);
      default: byte_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= FS_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      byte_no <= '0;
      wr_idx  <= '0;
      wr_data <= '0;
      wr_en   <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state   <= FS_SHIFT;
        bit_cnt <= '0;
        byte_no <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= FS_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          FS_SHIFT: begin
            if (scl_rise && bit_cnt != BITS) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_q};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == BITS) begin
              state  <= FS_ACK;
              sda_oe <= byte_ok;
              if (byte_no == 2'd1) wr_idx <= shreg[IDX_W-1:0];
              if (byte_no == 2'd2) begin
                wr_en   <= 1'b1;
                wr_data <= shreg;
              end
            end
          end
          FS_ACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              if (sda_oe && byte_no != 2'd2) begin
                byte_no <= byte_no + 1'b1;
                state   <= FS_SHIFT;
              end else begin
                state <= FS_HOLD;
              end
            end
          end
          default: begin
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/vfe_cfg_regs.sv
`timescale 1ns/1ps
module vfe_cfg_regs
  import vfe_cfg_pkg::*;
#(
  parameter int unsigned        N_CH     = 3,
  parameter logic [BYTE_W-1:0]  DEF_CUT  = 8'h00,
  parameter logic [2*N_CH-1:0]  DEF_TYPE = 6'b01_01_00,
  parameter logic [3:0]         DEF_CTRL = 4'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              mux_pin,
  output logic [BYTE_W-1:0] cut_code,
  output logic [2*N_CH-1:0] chan_mode,
  output logic              power_down,
  output logic              sel_b,
  output logic              filt_active,
  output logic [N_CH-2:0]   half_en
);
  localparam ctrl_t CTRL_RST = ctrl_t'(DEF_CTRL);

  logic [BYTE_W-1:0] cut_q;
  logic [2*N_CH-1:0] type_q;
  logic [2*N_CH-1:0] type_wr;
  ctrl_t             ctrl_q;

  // channel 1 takes the top pair of the data byte, later channels follow downward
  for (genvar c = 0; c < N_CH; c++) begin : g_pair
    assign type_wr[2*c +: 2] = wr_data[BYTE_W-1-2*c -: 2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cut_q  <= DEF_CUT;
      type_q <= DEF_TYPE;
      ctrl_q <= CTRL_RST;
    end else if (wr_en) begin
      case (wr_idx)
        IDX_CUT:  cut_q  <= wr_data;
        IDX_TYPE: type_q <= type_wr;
        IDX_CTRL: ctrl_q <= ctrl_t'(wr_data[BYTE_W-1 -: 4]);
        default: begin
        end
      endcase
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_mode
    logic [1:0] mode_r;
    always_ff @(posedge clk) begin
      if (rst) mode_r <= decode_pair(DEF_TYPE[2*c +: 2]);
      else     mode_r <= decode_pair(type_q[2*c +: 2]);
    end
    assign chan_mode[2*c +: 2] = mode_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cut_code    <= DEF_CUT;
      power_down  <= CTRL_RST.pd;
      sel_b       <= CTRL_RST.mux;
      filt_active <= ~CTRL_RST.byp;
      half_en     <= {(N_CH-1){CTRL_RST.half & ~CTRL_RST.byp}};
    end else begin
      cut_code    <= cut_q;
      power_down  <= ctrl_q.pd;
      sel_b       <= mux_pin | ctrl_q.mux;
      filt_active <= ~ctrl_q.byp;
      half_en     <= {(N_CH-1){ctrl_q.half & ~ctrl_q.byp}};
    end
  end

endmodule

// File: rtl/vfe_i2c_cfg.sv
`timescale 1ns/1ps
module vfe_i2c_cfg
  import vfe_cfg_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       N_CH        = 3,
  parameter logic [6:0]        ADDR_BASE   = 7'h48,
  parameter logic [7:0]        DEF_CUT     = 8'h00,
  parameter logic [2*N_CH-1:0] DEF_TYPE    = 6'b01_01_00,
  parameter logic [3:0]        DEF_CTRL    = 4'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_sel,
  input  logic              mux_pin,
  output logic [7:0]        cut_code,
  output logic [2*N_CH-1:0] chan_mode,
  output logic              power_down,
  output logic              sel_b,
  output logic              filt_active,
  output logic [N_CH-2:0]   half_en
);
  logic              sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0]        dev_addr;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;

  // strap decode: low, high, open give consecutive addresses
  always_ff @(posedge clk) begin
    if (rst)              dev_addr <= ADDR_BASE;
    else if (addr_sel[1]) dev_addr <= ADDR_BASE + 7'd2;
    else if (addr_sel[0]) dev_addr <= ADDR_BASE + 7'd1;
    else                  dev_addr <= ADDR_BASE;
  end

  vfe_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  vfe_i2c_wr_fsm #(.ADDR_W(7)) u_fsm (
    .clk(clk), .rst(rst), .sda_q(sda_q), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .dev_addr(dev_addr), .sda_oe(sda_oe), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  vfe_cfg_regs #(
    .N_CH(N_CH), .DEF_CUT(DEF_CUT), .DEF_TYPE(DEF_TYPE), .DEF_CTRL(DEF_CTRL)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .mux_pin(mux_pin), .cut_code(cut_code), .chan_mode(chan_mode),
    .power_down(power_down), .sel_b(sel_b), .filt_active(filt_active),
    .half_en(half_en)
  );

endmodule

// File: rtl/vfe_i2c_cfg_chk.sv
`timescale 1ns/1ps
module vfe_i2c_cfg_chk #(
  parameter int unsigned N_CH = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              mux_pin,
  input logic              sel_b,
  input logic              filt_active,
  input logic [N_CH-2:0]   half_en,
  input logic [2*N_CH-1:0] chan_mode
);

  a_r4_ack_rise_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  a_r4_ack_fall_scl_low: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> !scl_i);

  a_r8_pin_forces_b: assert property (@(posedge clk) disable iff (rst)
    mux_pin |=> sel_b);

  a_r9_no_half_in_bypass: assert property (@(posedge clk) disable iff (rst)
    !filt_active |-> (half_en == '0));

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    a_r6_no_reserved_mode: assert property (@(posedge clk) disable iff (rst)
      chan_mode[2*c +: 2] != 2'b11);
  end

endmodule

bind vfe_i2c_cfg vfe_i2c_cfg_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .mux_pin(mux_pin),
  .sel_b(sel_b), .filt_active(filt_active), .half_en(half_en),
  .chan_mode(chan_mode)
);

// File: tb/vfe_i2c_cfg_bench.sv
`timescale 1ns/1ps
module vfe_i2c_cfg_bench;
  localparam int Q  = 30;
  localparam int NV = 15;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic       scl_m = 1'b1, sda_m = 1'b1, mux_pin = 1'b0;
  logic [1:0] addr_sel = 2'b00;
  logic       sda_oe, power_down, sel_b, filt_active;
  logic [7:0] cut_code;
  logic [5:0] chan_mode;
  logic [1:0] half_en;
  logic       sda_line;
  assign sda_line = sda_m & ~sda_oe;

  vfe_i2c_cfg u_vfe_i2c_cfg (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .mux_pin(mux_pin), .cut_code(cut_code),
    .chan_mode(chan_mode), .power_down(power_down), .sel_b(sel_b),
    .filt_active(filt_active), .half_en(half_en)
  );

  int checks = 0, errors = 0;

  // bench model of the three registers
  logic [7:0] m_cut = 8'h00, m_type = 8'h14;
  logic m_pd = 0, m_mux = 0, m_half = 0, m_byp = 0;

  // {sel, address byte, index byte, data byte, expected acks addr/idx/data}
  localparam logic [28:0] VEC [0:NV-1] = '{
    {2'b00, 8'h90, 8'h01, 8'hA5, 3'b111}, // R1 R5 low strap
    {2'b01, 8'h92, 8'h02, 8'hB4, 3'b111}, // R1 R6 high strap, direct/direct/bias
    {2'b10, 8'h94, 8'h03, 8'hF0, 3'b111}, // R1 R7 R9 open strap, all flags
    {2'b11, 8'h94, 8'h03, 8'h2F, 3'b111}, // R1 R7 R9 open strap, low nibble ignored
    {2'b00, 8'h92, 8'h01, 8'h11, 3'b000}, // R1 wrong address
    {2'b01, 8'h90, 8'h01, 8'h22, 3'b000}, // R1 wrong address for strap
    {2'b00, 8'h91, 8'h01, 8'h33, 3'b000}, // R2 read request
    {2'b00, 8'h90, 8'h04, 8'h44, 3'b100}, // R3 index out of range
    {2'b00, 8'h90, 8'h00, 8'h55, 3'b100}, // R3 index zero
    {2'b01, 8'h92, 8'h01, 8'h00, 3'b111}, // R4 R5 data zero acknowledged
    {2'b10, 8'h94, 8'h02, 8'h48, 3'b111}, // R6 bias/clamp/direct
    {2'b00, 8'h90, 8'h03, 8'h40, 3'b111}, // R7 R8 mux flag only
    {2'b00, 8'h90, 8'h02, 8'h03, 3'b111}, // R6 all clamp, bits 1:0 ignored
    {2'b00, 8'h90, 8'h01, 8'hFF, 3'b111}, // R4 R5 data all ones
    {2'b00, 8'h90, 8'h03, 8'h10, 3'b111}  // R9 bypass only
  };

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [18:0] exp_out();
    logic [5:0] m;
    for (int c = 0; c < 3; c++) begin
      logic [1:0] p;
      p = m_type[7-2*c -: 2];
      m[2*c +: 2] = p[1] ? 2'd2 : (p[0] ? 2'd1 : 2'd0);
    end
    return {m_cut, m, m_pd, mux_pin | m_mux, ~m_byp, {2{m_half & ~m_byp}}};
  endfunction

  function automatic logic [18:0] act_out();
    return {cut_code, chan_mode, power_down, sel_b, filt_active, half_en};
  endfunction

  task automatic apply(input logic [7:0] i, input logic [7:0] d);
    case (i)
      8'h01: m_cut = d;
      8'h02: m_type = d;
      8'h03: {m_pd, m_mux, m_half, m_byp} = d[7:4];
      default: ;
    endcase
  endtask

  task automatic bus_start();
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int k = 7; k >= 0; k--) begin
      sda_m = b[k]; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
    end
    sda_m = 1; wq(Q); scl_m = 1; wq(Q);
    ack = ~sda_line;
    wq(Q); scl_m = 0; wq(Q);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic a0, a1, a2, a3;
    wq(10);
    rst = 0;
    wq(6);
    // R12 reset values
    chk("R12 reset outputs", 32'(act_out()), 32'(exp_out()));
    chk("R12 reset sda_oe", 32'(sda_oe), 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [28:0] e;
      e = VEC[v];
      addr_sel = e[28:27];
      wq(4);
      bus_start();
      put_byte(e[26:19], a0);
      put_byte(e[18:11], a1);
      put_byte(e[10:3], a2);
      bus_stop();
      wq(8);
      if (e[2:0] == 3'b111) apply(e[18:11], e[10:3]);
      chk("R1/R2/R3/R4 ack pattern", 32'({a0, a1, a2}), 32'(e[2:0]));
      chk("R5/R6/R7/R9 outputs", 32'(act_out()), 32'(exp_out()));
    end

    // R8 pin overrides a clear mux flag
    addr_sel = 2'b00;
    mux_pin = 1; wq(3);
    chk("R8 pin high selects B", 32'(sel_b), 32'd1);
    mux_pin = 0; wq(3);
    chk("R8 pin low, flag clear selects A", 32'(sel_b), 32'd0);

    // R10 a fourth byte is refused and changes nothing
    bus_start();
    put_byte(8'h90, a0); put_byte(8'h01, a1); put_byte(8'h3C, a2); put_byte(8'h77, a3);
    bus_stop(); wq(8);
    apply(8'h01, 8'h3C);
    chk("R10 extra byte no ack", 32'(a3), 32'd0);
    chk("R10 single write kept", 32'(act_out()), 32'(exp_out()));

    // R11 stop after index discards the frame
    bus_start();
    put_byte(8'h90, a0); put_byte(8'h02, a1);
    bus_stop(); wq(8);
    chk("R11 stop before data acks", 32'({a0, a1}), 32'd3);
    chk("R11 stop before data no write", 32'(act_out()), 32'(exp_out()));

    // R11 repeated start restarts the frame
    bus_start();
    put_byte(8'h90, a0); put_byte(8'h02, a1);
    bus_start();
    put_byte(8'h90, a0); put_byte(8'h01, a1); put_byte(8'hC3, a2);
    bus_stop(); wq(8);
    apply(8'h01, 8'hC3);
    chk("R11 repeated start acks", 32'({a0, a1, a2}), 32'd7);
    chk("R11 repeated start write", 32'(act_out()), 32'(exp_out()));

    // R13 value visible before the stop, right after the data acknowledge
    bus_start();
    put_byte(8'h90, a0); put_byte(8'h01, a1); put_byte(8'h5A, a2);
    chk("R13 cut_code after data ack", 32'(cut_code), 32'h5A);
    bus_stop(); wq(8);
    apply(8'h01, 8'h5A);
    chk("R13 outputs after stop", 32'(act_out()), 32'(exp_out()));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule